// File: doc/BRIEF.md
# 64-bit Snapshot System Timer

This block is a free-running 64-bit tick counter with a small 32-bit register port. A prescaler turns the input clock into ticks: one counter step every 2×(DIV+1) input clocks. Software never reads the live count directly when it needs a coherent value. It writes a capture command, and then reads two shadow words that were loaded from the full 64-bit count on one clock edge. Both counter halves can also be written, so a saved value can be put back after a low-power period.

Six 32-bit compare channels watch the low half of the count. Each channel has a sticky pending flag and an interrupt mask bit. The interrupt line is the OR of the pending flags whose mask bit is set. The last channel doubles as a watchdog. When its enable bit is set, a match on that channel gives a one-clock pulse on the reset output.

The prescaler is a two-state machine. In PH_FIRST it counts DIV+1 clocks and then takes the transition end-of-half to PH_SECOND. In PH_SECOND it counts DIV+1 more clocks and emits the tick on the last of them, then takes the end-of-half transition back to PH_FIRST. A write to the divider register is the restart transition: it sends either state back to PH_FIRST with the count at zero.

Top module: `tick64_timer`

The register word index is bus_addr[5:2]. The byte offsets are:

| Offset | Register |
|---|---|
| 0x00 | counter low half (live) |
| 0x04 | counter high half (live) |
| 0x08 to 0x1C | compare channels 0 to 5 |
| 0x20 | pending flags, bits 5:0, write 1 to clear |
| 0x24 | interrupt mask, bits 5:0 |
| 0x28 | watchdog enable, bit 0 |
| 0x2C | divider DIV |
| 0x30 | capture command, bit 0; always reads 0 |
| 0x34 | captured low half |
| 0x38 | captured high half |

## Requirements
- R1: While reset is asserted, every register at offsets 0x00 to 0x38 reads zero, and irq_o and wdog_rst_o are low.
- R2: Writing offset 0x00 or 0x04 replaces that half of the counter. Any counter-half write cancels the increment in that cycle.
- R3: After a divider write on edge E, the counter steps on edges E+P, E+2P, and so on, where P = 2×(DIV+1). Between steps it holds its value.
- R4: Writing offset 0x30 with bit 0 set copies the 64-bit count, as it stood before that edge, into offsets 0x34 (low) and 0x38 (high). Those registers keep their value until the next such write. A write to 0x30 with bit 0 clear has no effect.
- R5: A step from low half 0xFFFFFFFF carries into the high half.
- R6: Pending bit i sets on the tick edge where the low half becomes equal to compare channel i. The bit is not set on any earlier edge.
- R7: Pending bits stay set until a 1 is written to them at offset 0x20. Writing 0 to a bit leaves it unchanged. If a set and a clear hit the same edge, the set wins.
- R8: irq_o is high exactly when some pending bit has its mask bit (offset 0x24, bit i) set. Pending bits still set while their mask bit is clear. Changing the mask leaves the compare values unchanged.
- R9: When watchdog enable (offset 0x28, bit 0) is 1, a match on channel 5 drives wdog_rst_o high for exactly one clock, in the cycle after the match edge. When the enable is 0, no pulse occurs, but the pending bit still sets.
- R10: A divider write restarts the prescaler phase, and the increment due on that edge is dropped.
- R11: The compare, mask, enable and divider registers read back what was written, limited to their implemented bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Masked OR of the pending flags |
| wdog_rst_o | output | 1 | One-clock watchdog reset pulse |

## Verification
The bench uses the default parameters: 32-bit data, six channels, watchdog on channel 5 and a 6-bit address. With the divider held at 0, 1 and 3, a compare match arrives within a few dozen clocks. Presetting the low half to 0xFFFFFFFE brings the carry into the high half within reach. Each expected count comes from the edge number of the last divider write, so the restart rule and the capture timing are checked to the exact cycle.

// File: rtl/tick64_pkg.sv
package tick64_pkg;

    // Prescaler half-period phases
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    // Decoded write strobes for the single-instance registers
    typedef struct packed {
        logic cnt_lo;
        logic cnt_hi;
        logic sts;
        logic ien;
        logic wden;
        logic div;
        logic snap;
    } wr_strobe_t;

endpackage

// File: rtl/tick64_prescaler.sv
module tick64_prescaler
    import tick64_pkg::*;
#(
    parameter int unsigned DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    phase_e           ph_q, ph_d;
    logic [DIV_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (cnt_q == div_val);

    // next-state logic
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_FIRST:  if (at_end) ph_d = PH_SECOND;
            PH_SECOND: if (at_end) ph_d = PH_FIRST;
            default:   ph_d = PH_FIRST;
        endcase
        if (restart) ph_d = PH_FIRST;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_FIRST;
        else        ph_q <= ph_d;
    end

    // clocks within the current half
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (restart || at_end) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    // outputs
    always_comb begin
        tick = 1'b0;
        unique case (ph_q)
            PH_SECOND: tick = at_end & ~restart;
            default:   tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/tick64_counter.sv
module tick64_counter #(
    parameter int unsigned CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [CNT_W/2-1:0] wdata,
    input  logic              snap_req,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  snap
);

    localparam int unsigned HALF_W = CNT_W / 2;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt_q[HALF_W-1:0]     <= wdata;
            if (wr_hi) cnt_q[CNT_W-1:HALF_W] <= wdata;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        snap_q <= '0;
        else if (snap_req) snap_q <= cnt_q;
    end

    assign cnt  = cnt_q;
    assign snap = snap_q;

endmodule

// File: rtl/tick64_cmp_bank.sv
module tick64_cmp_bank #(
    parameter int unsigned NCH     = 6,
    parameter int unsigned W       = 32,
    parameter int unsigned WDOG_CH = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inc,
    input  logic [W-1:0]          cnt_lo,
    input  logic [NCH-1:0]        cmp_wr,
    input  logic [W-1:0]          wdata,
    input  logic                  sts_wr,
    input  logic                  ien_wr,
    input  logic                  wden_wr,
    output logic [NCH-1:0][W-1:0] cmp,
    output logic [NCH-1:0]        sts,
    output logic [NCH-1:0]        ien,
    output logic                  wden,
    output logic                  irq,
    output logic                  wdog
);

    logic [NCH-1:0][W-1:0] cmp_q;
    logic [NCH-1:0]        sts_q;
    logic [NCH-1:0]        hit;
    logic [NCH-1:0]        ien_q;
    logic                  wden_q;
    logic                  wdog_q;
    logic [W-1:0]          nxt_lo;

    assign nxt_lo = cnt_lo + 1'b1;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign hit[g] = inc && (nxt_lo == cmp_q[g]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cmp_q[g] <= '0;
            else if (cmp_wr[g]) cmp_q[g] <= wdata;
        end

        // set has priority over the write-one clear
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 sts_q[g] <= 1'b0;
            else if (hit[g])            sts_q[g] <= 1'b1;
            else if (sts_wr && wdata[g]) sts_q[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q  <= '0;
            wden_q <= 1'b0;
            wdog_q <= 1'b0;
        end else begin
            if (ien_wr)  ien_q  <= wdata[NCH-1:0];
            if (wden_wr) wden_q <= wdata[0];
            wdog_q <= hit[WDOG_CH] & wden_q;
        end
    end

    assign cmp  = cmp_q;
    assign sts  = sts_q;
    assign ien  = ien_q;
    assign wden = wden_q;
    assign irq  = |(sts_q & ien_q);
    assign wdog = wdog_q;

endmodule

// File: rtl/tick64_timer.sv
module tick64_timer
    import tick64_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NCH     = 6,
    parameter int unsigned WDOG_CH = NCH - 1,
    parameter int unsigned ADDR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              wdog_rst_o
);

    localparam int unsigned CNT_W   = 2 * DATA_W;
    localparam int unsigned IDX_W   = ADDR_W - 2;
    localparam int unsigned CMP_B_I = 2;
    localparam logic [IDX_W-1:0] IX_CNT_LO = IDX_W'(0);
    localparam logic [IDX_W-1:0] IX_CNT_HI = IDX_W'(1);
    localparam logic [IDX_W-1:0] IX_STS    = IDX_W'(CMP_B_I + NCH);
    localparam logic [IDX_W-1:0] IX_IEN    = IDX_W'(CMP_B_I + NCH + 1);
    localparam logic [IDX_W-1:0] IX_WDEN   = IDX_W'(CMP_B_I + NCH + 2);
    localparam logic [IDX_W-1:0] IX_DIV    = IDX_W'(CMP_B_I + NCH + 3);
    localparam logic [IDX_W-1:0] IX_SNAP   = IDX_W'(CMP_B_I + NCH + 4);
    localparam logic [IDX_W-1:0] IX_SNP_LO = IDX_W'(CMP_B_I + NCH + 5);
    localparam logic [IDX_W-1:0] IX_SNP_HI = IDX_W'(CMP_B_I + NCH + 6);

    logic [IDX_W-1:0]           idx;
    logic                       unused_addr_lsb;
    wr_strobe_t                 wr;
    logic [NCH-1:0]             cmp_wr;
    logic [DATA_W-1:0]          div_q;
    logic                       tick;
    logic                       cnt_wr;
    logic                       inc;
    logic                       snap_req;
    logic [CNT_W-1:0]           cnt_q;
    logic [CNT_W-1:0]           snap_q;
    logic [NCH-1:0][DATA_W-1:0] cmp_q;
    logic [NCH-1:0]             sts_q;
    logic [NCH-1:0]             ien_q;
    logic                       wden_q;

    assign idx             = bus_addr[ADDR_W-1:2];
    assign unused_addr_lsb = ^bus_addr[1:0];

    // write decode
    always_comb begin
        wr.cnt_lo = bus_we && (idx == IX_CNT_LO);
        wr.cnt_hi = bus_we && (idx == IX_CNT_HI);
        wr.sts    = bus_we && (idx == IX_STS);
        wr.ien    = bus_we && (idx == IX_IEN);
        wr.wden   = bus_we && (idx == IX_WDEN);
        wr.div    = bus_we && (idx == IX_DIV);
        wr.snap   = bus_we && (idx == IX_SNAP);
    end

    for (genvar g = 0; g < NCH; g++) begin : g_cmp_dec
        assign cmp_wr[g] = bus_we && (idx == IDX_W'(CMP_B_I + g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      div_q <= '0;
        else if (wr.div) div_q <= bus_wdata;
    end

    assign cnt_wr   = wr.cnt_lo | wr.cnt_hi;
    assign inc      = tick & ~cnt_wr & ~wr.div;
    assign snap_req = wr.snap & bus_wdata[0];

    tick64_prescaler #(
        .DIV_W (DATA_W)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr.div),
        .div_val (div_q),
        .tick    (tick)
    );

    tick64_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (inc),
        .wr_lo    (wr.cnt_lo),
        .wr_hi    (wr.cnt_hi),
        .wdata    (bus_wdata),
        .snap_req (snap_req),
        .cnt      (cnt_q),
        .snap     (snap_q)
    );

    tick64_cmp_bank #(
        .NCH     (NCH),
        .W       (DATA_W),
        .WDOG_CH (WDOG_CH)
    ) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (inc),
        .cnt_lo  (cnt_q[DATA_W-1:0]),
        .cmp_wr  (cmp_wr),
        .wdata   (bus_wdata),
        .sts_wr  (wr.sts),
        .ien_wr  (wr.ien),
        .wden_wr (wr.wden),
        .cmp     (cmp_q),
        .sts     (sts_q),
        .ien     (ien_q),
        .wden    (wden_q),
        .irq     (irq_o),
        .wdog    (wdog_rst_o)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            IX_CNT_LO: bus_rdata = cnt_q[DATA_W-1:0];
            IX_CNT_HI: bus_rdata = cnt_q[CNT_W-1:DATA_W];
            IX_STS:    bus_rdata = {{(DATA_W-NCH){1'b0}}, sts_q};
            IX_IEN:    bus_rdata = {{(DATA_W-NCH){1'b0}}, ien_q};
            IX_WDEN:   bus_rdata = {{(DATA_W-1){1'b0}}, wden_q};
            IX_DIV:    bus_rdata = div_q;
            IX_SNP_LO: bus_rdata = snap_q[DATA_W-1:0];
            IX_SNP_HI: bus_rdata = snap_q[CNT_W-1:DATA_W];
            default:   bus_rdata = '0;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (idx == IDX_W'(CMP_B_I + i)) bus_rdata = cmp_q[i];
        end
    end

endmodule

// File: rtl/tick64_timer_chk.sv
module tick64_timer_chk #(
    parameter int unsigned CNT_W   = 64,
    parameter int unsigned NCH     = 6,
    parameter int unsigned WDOG_CH = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_wr,
    input logic             snap_req,
    input logic             sts_wr,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] snap,
    input logic [NCH-1:0]   sts,
    input logic [NCH-1:0]   ien,
    input logic             irq_o,
    input logic             wdog_rst_o
);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1))); // R3

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(snap)); // R4

    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_wr |=> ((sts & $past(sts)) == $past(sts))); // R7

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq_o); // R8

    AST_WDOG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst_o |=> !wdog_rst_o); // R9

    AST_WDOG_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst_o |-> sts[WDOG_CH]); // R9

endmodule

bind tick64_timer tick64_timer_chk #(
    .CNT_W   (CNT_W),
    .NCH     (NCH),
    .WDOG_CH (WDOG_CH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_wr     (cnt_wr),
    .snap_req   (snap_req),
    .sts_wr     (wr.sts),
    .cnt        (cnt_q),
    .snap       (snap_q),
    .sts        (sts_q),
    .ien        (ien_q),
    .irq_o      (irq_o),
    .wdog_rst_o (wdog_rst_o)
);

// File: tb/tick64_timer_bench.sv
module tick64_timer_bench;

    localparam int DW = 32;
    localparam int AW = 6;

    localparam logic [AW-1:0] A_CNT_LO = 6'h00, A_CNT_HI = 6'h04,
                              A_CMP0 = 6'h08, A_CMP1 = 6'h0C, A_CMP5 = 6'h1C,
                              A_STS = 6'h20, A_IEN = 6'h24, A_WDEN = 6'h28,
                              A_DIV = 6'h2C, A_SNAP = 6'h30,
                              A_SNP_LO = 6'h34, A_SNP_HI = 6'h38;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;
    logic          wdog;

    tick64_timer u_tick64_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (addr),
        .bus_we     (we),
        .bus_wdata  (wdata),
        .bus_rdata  (rdata),
        .irq_o      (irq),
        .wdog_rst_o (wdog)
    );

    always #10 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] act_q[$];
    string         tag_q[$];
    event          item_ev;

    int unsigned last_edge, ediv, per;
    logic [63:0] base, snap_exp;

    // scoreboard compare
    function automatic void drain();
        while (exp_q.size() > 0) begin
            logic [DW-1:0] e, a;
            string t;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", t, a, e);
            end
        end
    endfunction

    // monitor
    initial forever begin
        @(item_ev);
        drain();
    end

    task automatic push(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        exp_q.push_back(exp);
        act_q.push_back(act);
        tag_q.push_back(tag);
        -> item_ev;
    endtask

    task automatic finish_run();
        #1;
        drain();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // all driver tasks start and end just after a falling edge
    task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; we = 1'b1; wdata = d;
        last_edge = cyc + 1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        addr = a;
        #1;
        push(rdata, exp, tag);
    endtask

    task automatic pin(input logic v, input logic exp, input string tag);
        push({{(DW-1){1'b0}}, v}, {{(DW-1){1'b0}}, exp}, tag);
    endtask

    task automatic wait_edge(input int unsigned n);
        while (cyc < n) @(negedge clk);
    endtask

    function automatic logic [63:0] model_at(input int unsigned l);
        return base + 64'((l - ediv - 1) / per);
    endfunction

    task automatic setup(input int unsigned d, input logic [31:0] hi, input logic [31:0] lo);
        bus_wr(A_CNT_LO, lo);
        bus_wr(A_CNT_HI, hi);
        bus_wr(A_DIV, d);
        ediv = last_edge;
        per  = 2 * (d + 1);
        base = {hi, lo};
    endtask

    task automatic latch_check(input string tag);
        bus_wr(A_SNAP, 32'h1);
        snap_exp = model_at(last_edge);
        rd(A_SNP_LO, snap_exp[31:0], tag);
        rd(A_SNP_HI, snap_exp[63:32], tag);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        for (int a = 0; a <= 14; a++) rd(AW'(a * 4), 32'h0, "R1 reset value");
        pin(irq, 1'b0, "R1 irq in reset");
        pin(wdog, 1'b0, "R1 wdog in reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3: half writes, DIV=0
        setup(0, 32'h0000_0012, 32'h0000_0100);
        wait_edge(ediv + 8);
        latch_check("R2 written halves");
        latch_check("R3 div0 step");

        // R3: DIV=3
        setup(3, 32'h0, 32'h0);
        wait_edge(ediv + 19);
        latch_check("R3 div3 early");
        wait_edge(ediv + 40);
        latch_check("R3 div3 later");

        // R4: hold and ignored command
        repeat (30) @(negedge clk);
        rd(A_SNP_LO, snap_exp[31:0], "R4 hold lo");
        rd(A_SNP_HI, snap_exp[63:32], "R4 hold hi");
        bus_wr(A_SNAP, 32'hFFFF_FFFE);
        rd(A_SNP_LO, snap_exp[31:0], "R4 bit0 clear ignored");
        latch_check("R4 new capture");

        // R10: divider rewrite restarts phase
        setup(1, 32'h0, 32'h50);
        wait_edge(ediv + 2);
        bus_wr(A_DIV, 32'd1);
        ediv = last_edge;
        wait_edge(ediv + 3);
        latch_check("R10 restart no early step");
        latch_check("R10 first step after restart");

        // R5: carry
        setup(0, 32'h7, 32'hFFFF_FFFE);
        wait_edge(ediv + 4);
        latch_check("R5 carry into high half");

        // R6/R7/R8: channel 1
        setup(1, 32'h0, 32'h0);
        bus_wr(A_CMP1, 32'd3);
        bus_wr(A_STS, 32'h3F);
        wait_edge(ediv + 11);
        rd(A_STS, 32'h0, "R6 not before match");
        wait_edge(ediv + 12);
        rd(A_STS, 32'h2, "R6 set at match");
        pin(irq, 1'b0, "R8 masked pending");
        bus_wr(A_IEN, 32'h2);
        pin(irq, 1'b1, "R8 enabled pending");
        bus_wr(A_IEN, 32'h0);
        pin(irq, 1'b0, "R8 re-masked");
        rd(A_CMP1, 32'd3, "R8 compare kept");
        bus_wr(A_STS, 32'h1);
        rd(A_STS, 32'h2, "R7 other bit untouched");
        bus_wr(A_STS, 32'h2);
        rd(A_STS, 32'h0, "R7 write one clears");
        bus_wr(A_CMP1, 32'h0);

        // R9: watchdog enabled
        setup(0, 32'h0, 32'h0);
        bus_wr(A_CMP5, 32'd2);
        bus_wr(A_WDEN, 32'h1);
        bus_wr(A_STS, 32'h3F);
        wait_edge(ediv + 3);
        pin(wdog, 1'b0, "R9 no pulse before match");
        wait_edge(ediv + 4);
        pin(wdog, 1'b1, "R9 pulse after match");
        rd(A_STS, 32'h20, "R9 pending ch5");
        wait_edge(ediv + 5);
        pin(wdog, 1'b0, "R9 pulse one cycle");

        // R9: watchdog disabled
        setup(0, 32'h0, 32'h0);
        bus_wr(A_WDEN, 32'h0);
        bus_wr(A_STS, 32'h3F);
        wait_edge(ediv + 4);
        pin(wdog, 1'b0, "R9 disabled no pulse");
        rd(A_STS, 32'h20, "R9 disabled still pending");
        wait_edge(ediv + 5);
        pin(wdog, 1'b0, "R9 disabled no late pulse");

        // R11: readback
        bus_wr(A_CMP0, 32'hA5A5_0001);
        rd(A_CMP0, 32'hA5A5_0001, "R11 compare readback");
        bus_wr(A_IEN, 32'hFFFF_FFFF);
        rd(A_IEN, 32'h3F, "R11 mask width");
        pin(irq, 1'b1, "R8 pending ch5 enabled");
        bus_wr(A_IEN, 32'h0);
        bus_wr(A_WDEN, 32'hFFFF_FFFF);
        rd(A_WDEN, 32'h1, "R11 enable width");
        bus_wr(A_WDEN, 32'h0);
        bus_wr(A_DIV, 32'd5);
        rd(A_DIV, 32'd5, "R11 divider readback");
        rd(A_SNAP, 32'h0, "R11 command reads zero");

        finish_run();
    end

endmodule